// File: doc/BRIEF.md
# Periodic Conversion Trigger Timer

This block paces a bank of simultaneously sampled converter channels. It counts down on an 8 MHz timebase and emits a trigger pulse, one clock wide, at a fixed interval. The interval is the programmed value plus one tick: a value V gives a period of (V + 1) / 8,000,000 seconds. The value sits in a 24-bit period register. Software reaches that register through a small register port. The port has a write strobe, a word address, per-byte write enables and a combinational read path.

Software first writes the period and sets the run-enable bit. It then writes a 1 to bit 0 of the start register. The counter loads the period and fires its first trigger one full period later. It then reloads after every trigger until software clears run-enable. The period register resets to zero, and zero is an illegal setting. While the timer is enabled, any value outside the legal window of 63 to 16,777,150 is clamped to the nearest limit and sets a sticky error flag. The lower limit of 63 (8 µs) matches the converter's minimum conversion time.

Top module: `conv_trigger_timer`

## Requirements
- R1: After reset the period register, the run-enable bit and both status bits read as 0, and `trig_o` is low.
- R2: Word address 0 holds the 24-bit period. `bus_be[b]` writes byte b from `bus_wdata[8b+7:8b]` for b = 0..2. `bus_be[3]` and data bits 31:24 are ignored, and bits 31:24 read back as 0. Address 1 bit 0 is run-enable. Address 2 (start) reads as 0.
- R3: A write to address 2 with `bus_be[0]`=1 and `bus_wdata[0]`=1 while run-enable is 1 starts the timer. The first trigger is seen V+1 clock cycles after the write edge. A start write with data bit 0 at 0, or one made while run-enable is 0, has no effect.
- R4: While running, triggers repeat every V+1 cycles. A start write while running restarts the phase from that write.
- R5: `trig_o` is high for exactly one clock cycle per trigger.
- R6: While run-enable is 1, a period value below 63 (including 0) is used as 63 and sets status bit 0 (configuration error).
- R7: While run-enable is 1, a period value above 16,777,150 is used as 16,777,150 and sets status bit 0. Legal values leave the flag clear.
- R8: Status bit 0 is sticky. It clears only when 1 is written to address 3 bit 0. Status bit 1 reads 1 while the timer is running.
- R9: Clearing run-enable stops the timer: running reads 0 and no further triggers occur.
- R10: A period write during a run takes effect at the next reload. The trigger already being counted keeps the old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address (0 period, 1 control, 2 start, 3 status) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte write enables |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| trig_o | output | 1 | Conversion trigger pulse |

## Verification
The checker assumes that no programmed period can make two triggers fall on adjacent cycles. Clamping guarantees this, because it keeps the effective value at 63 or more. The checker also assumes that a start strobe only counts while run-enable is already set. The stimulus therefore sets run-enable in its own bus write before every start. It disables the timer only just after a trigger, while the counter is far from zero, so that the one-cycle lag of the enable register cannot produce a trigger the scoreboard has no entry for. Out-of-range values are driven only for the flag and clamp checks. The upper limit is checked through its flag and never run to a trigger, since that period would exceed the bench's cycle budget.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  typedef enum logic [1:0] {
    RA_PERIOD = 2'd0,
    RA_CTRL   = 2'd1,
    RA_START  = 2'd2,
    RA_STAT   = 2'd3
  } reg_addr_e;

  localparam int unsigned BUS_W = 32;
  localparam int unsigned BE_W  = BUS_W / 8;
endpackage

// File: rtl/ctt_regs.sv
module ctt_regs
  import ctt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [BE_W-1:0]  be,
  input  logic             running,
  input  logic             cfg_err,
  output logic [CNT_W-1:0] period_q,
  output logic             enable_q,
  output logic             start_stb,
  output logic             err_clr,
  output logic [BUS_W-1:0] rdata
);
  localparam int unsigned PER_B = CNT_W / 8;

  logic [CNT_W-1:0] period_d;
  logic             enable_d;
  logic             per_sel, ctrl_sel;

  assign per_sel   = wr_en && (addr == RA_PERIOD);
  assign ctrl_sel  = wr_en && (addr == RA_CTRL);
  assign start_stb = wr_en && (addr == RA_START) && be[0] && wdata[0];
  assign err_clr   = wr_en && (addr == RA_STAT) && be[0] && wdata[0];

  always_comb begin
    period_d = period_q;
    for (int b = 0; b < PER_B; b++) begin
      if (per_sel && be[b]) period_d[b*8 +: 8] = wdata[b*8 +: 8];
    end
    enable_d = enable_q;
    if (ctrl_sel && be[0]) enable_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      enable_q <= 1'b0;
    end else begin
      period_q <= period_d;
      enable_q <= enable_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_addr_e'(addr))
      RA_PERIOD: rdata[CNT_W-1:0] = period_q;
      RA_CTRL:   rdata[0]         = enable_q;
      RA_START:  rdata            = '0;
      RA_STAT:   rdata[1:0]       = {running, cfg_err};
      default:   rdata            = '0;
    endcase
  end
endmodule

// File: rtl/ctt_range.sv
module ctt_range #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned MIN_VAL = 63,
  parameter int unsigned MAX_VAL = 16777150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  input  logic             err_clr,
  output logic [CNT_W-1:0] eff_val,
  output logic             cfg_err
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_VAL);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_VAL);

  logic too_low, too_high, err_set, err_d;

  assign too_low  = period < MIN_V;
  assign too_high = period > MAX_V;

  always_comb begin
    if (too_low)       eff_val = MIN_V;
    else if (too_high) eff_val = MAX_V;
    else               eff_val = period;
  end

  assign err_set = enable && (too_low || too_high);
  assign err_d   = err_set || (cfg_err && !err_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= err_d;
  end
endmodule

// File: rtl/ctt_counter.sv
module ctt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             trig_o
);
  logic [CNT_W-1:0] count_d;
  logic             running_d, trig_d, cnt_ce;

  assign cnt_ce = enable && (start || running);

  always_comb begin
    count_d   = count;
    running_d = running;
    trig_d    = 1'b0;
    if (!enable) begin
      running_d = 1'b0;
    end else if (start) begin
      count_d   = reload;
      running_d = 1'b1;
    end else if (running) begin
      if (count == '0) begin
        count_d = reload;
        trig_d  = 1'b1;
      end else begin
        count_d = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      trig_o  <= 1'b0;
    end else begin
      if (cnt_ce) count <= count_d;
      running <= running_d;
      trig_o  <= trig_d;
    end
  end
endmodule

// File: rtl/conv_trigger_timer.sv
module conv_trigger_timer
  import ctt_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned MIN_VAL = 63,
  parameter int unsigned MAX_VAL = 16777150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]  bus_be,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             trig_o
);
  logic [CNT_W-1:0] period_q, eff_val, count;
  logic             enable_q, start_stb, err_clr, cfg_err, running;

  ctt_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .be(bus_be), .running(running), .cfg_err(cfg_err),
    .period_q(period_q), .enable_q(enable_q), .start_stb(start_stb),
    .err_clr(err_clr), .rdata(bus_rdata)
  );

  ctt_range #(.CNT_W(CNT_W), .MIN_VAL(MIN_VAL), .MAX_VAL(MAX_VAL)) range_i (
    .clk(clk), .rst_n(rst_n), .enable(enable_q), .period(period_q),
    .err_clr(err_clr), .eff_val(eff_val), .cfg_err(cfg_err)
  );

  ctt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .enable(enable_q), .start(start_stb),
    .reload(eff_val), .count(count), .running(running), .trig_o(trig_o)
  );
endmodule

// File: rtl/ctt_checker.sv
module ctt_checker #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned MIN_VAL = 63,
  parameter int unsigned MAX_VAL = 16777150
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_o,
  input logic             running,
  input logic             enable,
  input logic             start,
  input logic             cfg_err,
  input logic             err_clr,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_VAL);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_VAL);

  // R5
  trig_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R3
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start) |=> running);

  // R9
  disable_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!running && !trig_o));

  // R6
  low_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (period < MIN_V)) |=> cfg_err);

  // R7
  high_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (period > MAX_V)) |=> cfg_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !err_clr) |=> cfg_err);

  // R4
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= MAX_V);
endmodule

bind conv_trigger_timer ctt_checker #(.CNT_W(CNT_W), .MIN_VAL(MIN_VAL), .MAX_VAL(MAX_VAL)) chk_i (
  .clk(clk), .rst_n(rst_n), .trig_o(trig_o), .running(running),
  .enable(enable_q), .start(start_stb), .cfg_err(cfg_err), .err_clr(err_clr),
  .period(period_q), .count(count)
);

// File: tb/conv_trigger_timer_tb_top.sv
module conv_trigger_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        trig_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_wr = 0;
  int exp_q[$];
  logic prev_trig = 1'b0;
  logic [31:0] rd;

  conv_trigger_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .trig_o(trig_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk);
    #1;
    last_wr = cyc;
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // driver: start and push the expected trigger cycles
  task automatic start_run(int v, int n);
    wr(2'd2, 32'h1, 4'h1);
    for (int k = 1; k <= n; k++) exp_q.push_back(last_wr + k * (v + 1));
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
  endtask

  // monitor: compare every trigger against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (trig_o && prev_trig) chk("R5 pulse width", 2, 1);
      if (trig_o) begin
        if (exp_q.size() == 0) chk("R4/R9 unexpected trigger cycle", cyc, -1);
        else chk("R3/R4/R10 trigger cycle", cyc, exp_q.pop_front());
      end
      prev_trig = trig_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdreg(2'd0, rd); chk("R1 period", int'(rd), 0);
    rdreg(2'd1, rd); chk("R1 enable", int'(rd), 0);
    rdreg(2'd3, rd); chk("R1 status", int'(rd), 0);
    chk("R1 trig", int'(trig_o), 0);

    // basic periodic run, period 100 -> 101 cycles, then disable (R4, R9)
    wr(2'd0, 32'h0000_0064, 4'hF);
    wr(2'd1, 32'h1, 4'h1);
    start_run(100, 3);
    drain();
    wr(2'd1, 32'h0, 4'h1);
    repeat (2) @(negedge clk);
    rdreg(2'd3, rd); chk("R9 running after disable", int'(rd[1]), 0);
    repeat (250) @(negedge clk);

    // R3 start with bit 0 clear, and start while disabled
    wr(2'd1, 32'h1, 4'h1);
    wr(2'd2, 32'h2, 4'h1);
    repeat (150) @(negedge clk);
    rdreg(2'd3, rd); chk("R3 bit0=0 start ignored", int'(rd[1]), 0);
    wr(2'd1, 32'h0, 4'h1);
    wr(2'd2, 32'h1, 4'h1);
    repeat (150) @(negedge clk);
    rdreg(2'd3, rd); chk("R3 disabled start ignored", int'(rd[1]), 0);

    // R2 partial writes
    wr(2'd0, 32'h0000_0100, 4'h2);
    rdreg(2'd0, rd); chk("R2 byte1 write", int'(rd), 32'h164);
    wr(2'd0, 32'hAB12_0000, 4'hC);
    rdreg(2'd0, rd); chk("R2 upper bytes", int'(rd), 32'h12_0164);
    wr(2'd0, 32'hFF00_0045, 4'hF);
    rdreg(2'd0, rd); chk("R2 word write", int'(rd), 32'h45);
    rdreg(2'd2, rd); chk("R2 start reads 0", int'(rd), 0);

    // R4 / R10: period 69, change to 80 mid run, then restart
    wr(2'd1, 32'h1, 4'h1);
    start_run(69, 2);
    drain();
    begin
      int t2;
      t2 = cyc;
      wr(2'd0, 32'h50, 4'h1);
      exp_q.push_back(t2 + 70);
      exp_q.push_back(t2 + 70 + 81);
    end
    drain();
    repeat (20) @(negedge clk);
    start_run(80, 1);   // R4 restart re-phases
    drain();
    wr(2'd1, 32'h0, 4'h1);
    repeat (100) @(negedge clk);

    // R6 low clamp and R8 sticky flag
    wr(2'd0, 32'd10, 4'hF);
    repeat (2) @(negedge clk);
    rdreg(2'd3, rd); chk("R6 no flag while disabled", int'(rd[0]), 0);
    wr(2'd1, 32'h1, 4'h1);
    repeat (2) @(negedge clk);
    rdreg(2'd3, rd); chk("R6 flag on low value", int'(rd[0]), 1);
    start_run(63, 2);
    drain();
    wr(2'd1, 32'h0, 4'h1);
    repeat (2) @(negedge clk);
    rdreg(2'd3, rd); chk("R8 flag sticky", int'(rd[0]), 1);
    wr(2'd3, 32'h1, 4'h1);
    repeat (2) @(negedge clk);
    rdreg(2'd3, rd); chk("R8 flag cleared", int'(rd[0]), 0);

    // R6 zero value
    wr(2'd0, 32'd0, 4'hF);
    wr(2'd1, 32'h1, 4'h1);
    repeat (2) @(negedge clk);
    rdreg(2'd3, rd); chk("R6 zero flagged", int'(rd[0]), 1);
    wr(2'd1, 32'h0, 4'h1);
    wr(2'd3, 32'h1, 4'h1);

    // R7 high clamp
    wr(2'd0, 32'h00FF_FFFF, 4'hF);
    wr(2'd1, 32'h1, 4'h1);
    repeat (2) @(negedge clk);
    rdreg(2'd3, rd); chk("R7 high flagged", int'(rd[0]), 1);
    wr(2'd1, 32'h0, 4'h1);
    wr(2'd3, 32'h1, 4'h1);
    wr(2'd0, 32'd16777150, 4'hF);
    wr(2'd1, 32'h1, 4'h1);
    repeat (2) @(negedge clk);
    rdreg(2'd3, rd); chk("R7 max legal not flagged", int'(rd[0]), 0);
    wr(2'd1, 32'h0, 4'h1);

    // minimum legal value 63 runs at 64 cycles without flag (R6, R5)
    wr(2'd0, 32'd63, 4'hF);
    wr(2'd1, 32'h1, 4'h1);
    start_run(63, 3);
    drain();
    wr(2'd1, 32'h0, 4'h1);
    rdreg(2'd3, rd); chk("R6 min legal not flagged", int'(rd[0]), 0);
    repeat (100) @(negedge clk);

    chk("scoreboard empty", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule